// File: doc/BRIEF.md
# Key-Unlocked Serial Timekeeper Access Port

This block sits beside a RAM on an asynchronous SRAM-style bus and listens to its chip-enable, output-enable and write-enable strobes together with a single data line. Ordinary software traffic reaches the RAM untouched. A hidden path to a timekeeper opens only after a 64-bit key has been written, one bit per write cycle, through ordinary memory writes. Any read cycle during this phase restarts the key search. The key writes still land in RAM, so software normally sets aside one scratch location for them.

Once the key has matched, the block asserts a memory-inhibit flag. The next 64 bus cycles move the eight 8-bit timekeeper registers serially on the data line. Each cycle is a read or a write, chosen by its strobes. Read data comes from a snapshot that is taken at the moment of unlock. Written bits are gathered per register, and a register is handed to the timekeeper on a parallel write port only when its last bit has arrived. After the 64th cycle the port locks again.

A transfer can be cut short by an external reset input, but only when the timekeeper's reset-enable bit allows it. Strobes are synchronised to the system clock. A bus cycle is recognised when chip enable returns high.

Top module: `keyed_serial_port`

## Requirements
- R1: After synchronous reset the port is locked: `mem_inhibit`, `dq0_oe` and `tk_wr_en` are 0.
- R2: The key is the 64-bit value 0x5CA33AC55CA33AC5. Key bit i is bit i of that value, so the byte C5 goes first, least significant bit first. After 64 selected write cycles whose data bits equal key bits 0..63 in turn, `mem_inhibit` rises. It stays 0 during the key cycles themselves.
- R3: A selected write whose bit differs from the expected key bit freezes the key position, and all later selected writes are ignored until a read. A full correct key sent after such a mismatch, with no read in between, leaves the port locked.
- R4: A selected read cycle (chip enable low, write enable high, output enable low) while locked returns the key position to bit 0 and clears a mismatch. Key bits already matched before the read no longer count.
- R5: A cycle with `bus_sel` low has no effect on key matching or on data transfer.
- R6: While unlocked, during a selected read cycle `dq0_oe` is 1 and `dq0_out` equals bit n of the value `tk_rd_data` held at unlock, where n counts the transfer cycles from 0. Later changes of `tk_rd_data` are not seen.
- R7: Transfer cycles 8g..8g+7 form register g. At cycle 8g+7, if any of those cycles was a write, a one-cycle `tk_wr_en` pulse carries `tk_wr_idx`=g. `tk_wr_byte` holds the written bits, and snapshot bits at positions that were read. A register with no write gives no pulse.
- R8: After the 64th transfer cycle the port is locked again and `mem_inhibit` returns to 0.
- R9: While unlocked, with bit 28 of `tk_rd_data` (register 3, bit 4) at 0, a low `xfer_rst_n` aborts the transfer: the port locks, and no pulse is given for a partly transferred register. With that bit at 1, `xfer_rst_n` is ignored.
- R10: A bus cycle counts once, when chip enable rises. A chip-enable pulse with both write and output enable high is no cycle: it neither restarts the key nor advances it. The effect of a cycle shows at the third clock edge after chip enable rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_ce_n | input | 1 | Chip enable, active low, asynchronous |
| bus_oe_n | input | 1 | Output enable, active low |
| bus_we_n | input | 1 | Write enable, active low |
| bus_sel | input | 1 | High when the bus address falls in this block's range |
| bus_dq0_i | input | 1 | Data line input |
| xfer_rst_n | input | 1 | Transfer abort input, active low |
| tk_rd_data | input | 64 | Current timekeeper registers, register g at bits 8g+7..8g |
| mem_inhibit | output | 1 | High while the port is unlocked; RAM access must be blocked |
| dq0_out | output | 1 | Serial read data |
| dq0_oe | output | 1 | Drive enable for `dq0_out` |
| tk_wr_en | output | 1 | One-cycle register write strobe |
| tk_wr_idx | output | 3 | Register index of the write |
| tk_wr_byte | output | 8 | Register value of the write |

## Verification
The assertions assume that the bus strobes, select and data stay steady for several clocks while chip enable is low. They also assume that chip enable stays high long enough between cycles for each synchronised edge to be seen once, and that `tk_rd_data` bit 28 does not change while the abort input is low. The stimulus holds every cycle low for three clocks and high for five. It drives all inputs on falling clock edges and changes `tk_rd_data` only while no abort is pending. Under these conditions the three-edge delay from a strobe to its effect is fixed, and a behavioural model in the bench can be compared against the outputs on every clock.

// File: rtl/skp_pkg.sv
package skp_pkg;

    localparam int          KEY_BITS   = 64;
    localparam logic [63:0] UNLOCK_KEY = 64'h5CA3_3AC5_5CA3_3AC5;

    typedef struct packed {
        logic ce_n;
        logic oe_n;
        logic we_n;
        logic sel;
        logic dat;
        logic rst_n;
    } bus_smp_t;

    localparam bus_smp_t BUS_IDLE = '{ce_n: 1'b1, oe_n: 1'b1, we_n: 1'b1,
                                      sel: 1'b0, dat: 1'b0, rst_n: 1'b1};

    typedef enum logic [1:0] {
        EV_NONE  = 2'd0,
        EV_READ  = 2'd1,
        EV_WRITE = 2'd2
    } ev_kind_t;

    typedef struct packed {
        ev_kind_t kind;
        logic     dat;
    } bus_ev_t;

    // Write enable wins over output enable; unselected cycles vanish.
    function automatic ev_kind_t classify(bus_smp_t s);
        if (!s.sel)       return EV_NONE;
        else if (!s.we_n) return EV_WRITE;
        else if (!s.oe_n) return EV_READ;
        else              return EV_NONE;
    endfunction

endpackage

// File: rtl/skp_bus_sync.sv
module skp_bus_sync
    import skp_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    bus_ce_n,
    input  logic    bus_oe_n,
    input  logic    bus_we_n,
    input  logic    bus_sel,
    input  logic    bus_dq0_i,
    input  logic    xfer_rst_n,
    output logic    live_ce_n,
    output logic    live_oe_n,
    output logic    live_we_n,
    output logic    live_sel,
    output logic    live_rst_n,
    output bus_ev_t ev
);

    bus_smp_t raw;
    bus_smp_t stg [SYNC_STAGES];
    bus_smp_t last;
    bus_smp_t prev;

    assign raw = '{ce_n: bus_ce_n, oe_n: bus_oe_n, we_n: bus_we_n,
                   sel: bus_sel, dat: bus_dq0_i, rst_n: xfer_rst_n};

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < SYNC_STAGES; i++) stg[i] <= BUS_IDLE;
            prev <= BUS_IDLE;
        end else begin
            stg[0] <= raw;
            for (int i = 1; i < SYNC_STAGES; i++) stg[i] <= stg[i-1];
            prev <= stg[SYNC_STAGES-1];
        end
    end

    assign last       = stg[SYNC_STAGES-1];
    assign live_ce_n  = last.ce_n;
    assign live_oe_n  = last.oe_n;
    assign live_we_n  = last.we_n;
    assign live_sel   = last.sel;
    assign live_rst_n = last.rst_n;

    // A cycle is taken from the last sample seen with chip enable low.
    assign ev.kind = (!prev.ce_n && last.ce_n) ? classify(prev) : EV_NONE;
    assign ev.dat  = prev.dat;

    // R10: one rising chip-enable edge yields a single event
    assert_one_event_per_pulse_R10: assert property (@(posedge clk) disable iff (rst)
        (ev.kind != EV_NONE) |=> (ev.kind == EV_NONE));

endmodule

// File: rtl/skp_key_match.sv
module skp_key_match
    import skp_pkg::*;
#(
    parameter int PTR_W = $clog2(KEY_BITS)
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    locked_i,
    input  bus_ev_t ev,
    output logic    done_o
);

    logic [PTR_W-1:0] ptr;
    logic             miss;
    logic             bit_ok;

    assign bit_ok = (ev.dat == UNLOCK_KEY[ptr]);
    assign done_o = locked_i && (ev.kind == EV_WRITE) && !miss && bit_ok
                    && (ptr == PTR_W'(KEY_BITS - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr  <= '0;
            miss <= 1'b0;
        end else if (locked_i) begin
            case (ev.kind)
                EV_READ: begin
                    ptr  <= '0;
                    miss <= 1'b0;
                end
                EV_WRITE: begin
                    if (!miss) begin
                        if (!bit_ok)     miss <= 1'b1;
                        else if (done_o) ptr  <= '0;
                        else             ptr  <= ptr + PTR_W'(1);
                    end
                end
                default: ;
            endcase
        end
    end

    // R3: after a mismatch only a read can move the key position
    assert_miss_freezes_R3: assert property (@(posedge clk) disable iff (rst)
        (miss && ev.kind != EV_READ) |=> $stable(ptr));

    // R4: a read while locked restarts the search cleanly
    assert_read_restarts_R4: assert property (@(posedge clk) disable iff (rst)
        (locked_i && ev.kind == EV_READ) |=> (ptr == '0 && !miss));

endmodule

// File: rtl/skp_xfer.sv
module skp_xfer
    import skp_pkg::*;
#(
    parameter int REG_COUNT = 8,
    parameter int REG_W     = 8,
    parameter int RSTEN_BIT = 28,
    localparam int TOTAL    = REG_COUNT * REG_W,
    localparam int CNT_W    = $clog2(TOTAL),
    localparam int IDX_W    = $clog2(REG_COUNT),
    localparam int BIT_W    = $clog2(REG_W)
) (
    input  logic             clk,
    input  logic             rst,
    input  bus_ev_t          ev,
    input  logic             start_i,
    input  logic             live_ce_n,
    input  logic             live_oe_n,
    input  logic             live_we_n,
    input  logic             live_sel,
    input  logic             live_rst_n,
    input  logic [TOTAL-1:0] tk_rd_data,
    output logic             unlocked_o,
    output logic             dq_out,
    output logic             dq_oe,
    output logic             wr_en,
    output logic [IDX_W-1:0] wr_idx,
    output logic [REG_W-1:0] wr_byte
);

    logic             unlocked;
    logic [CNT_W-1:0] cnt;
    logic [TOTAL-1:0] shadow;
    logic [REG_W-1:0] asm_q;
    logic [REG_W-1:0] nxt_byte;
    logic             dirty;
    logic             abort;
    logic             step;
    logic             is_wr;
    logic             grp_end;
    logic [BIT_W-1:0] bpos;
    logic [IDX_W-1:0] grp;
    logic [IDX_W-1:0] nidx;

    assign bpos    = cnt[BIT_W-1:0];
    assign grp     = cnt[CNT_W-1:BIT_W];
    assign nidx    = grp + IDX_W'(1);
    assign grp_end = (bpos == BIT_W'(REG_W - 1));
    assign is_wr   = (ev.kind == EV_WRITE);
    assign step    = unlocked && (ev.kind != EV_NONE);
    assign abort   = unlocked && !tk_rd_data[RSTEN_BIT] && !live_rst_n;

    always_comb begin
        nxt_byte = asm_q;
        if (is_wr) nxt_byte[bpos] = ev.dat;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            unlocked <= 1'b0;
            cnt      <= '0;
            shadow   <= '0;
            asm_q    <= '0;
            dirty    <= 1'b0;
            wr_en    <= 1'b0;
            wr_idx   <= '0;
            wr_byte  <= '0;
        end else begin
            wr_en <= 1'b0;
            if (abort) begin
                unlocked <= 1'b0;
                cnt      <= '0;
                dirty    <= 1'b0;
            end else if (!unlocked && start_i) begin
                unlocked <= 1'b1;
                cnt      <= '0;
                shadow   <= tk_rd_data;
                asm_q    <= tk_rd_data[REG_W-1:0];
                dirty    <= 1'b0;
            end else if (step) begin
                cnt <= cnt + CNT_W'(1);
                if (grp_end) begin
                    if (dirty || is_wr) begin
                        wr_en   <= 1'b1;
                        wr_idx  <= grp;
                        wr_byte <= nxt_byte;
                    end
                    dirty <= 1'b0;
                    asm_q <= shadow[nidx*REG_W +: REG_W];
                    if (cnt == CNT_W'(TOTAL - 1)) unlocked <= 1'b0;
                end else begin
                    asm_q <= nxt_byte;
                    dirty <= dirty | is_wr;
                end
            end
        end
    end

    assign unlocked_o = unlocked;
    assign dq_out     = shadow[cnt];
    assign dq_oe      = unlocked && !live_ce_n && !live_oe_n && live_we_n && live_sel;

    // R7: a register write strobe only follows an unlocked cycle
    assert_commit_when_unlocked_R7: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> $past(unlocked));

    // R8: the last transfer cycle closes the port
    assert_stop_after_last_R8: assert property (@(posedge clk) disable iff (rst)
        (step && !abort && cnt == CNT_W'(TOTAL - 1)) |=> !unlocked);

    // R9: an allowed abort locks the port with no register write
    assert_abort_no_commit_R9: assert property (@(posedge clk) disable iff (rst)
        abort |=> (!unlocked && !wr_en));

endmodule

// File: rtl/keyed_serial_port.sv
module keyed_serial_port
    import skp_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int REG_COUNT   = 8,
    parameter int REG_W       = 8,
    parameter int RSTEN_BIT   = 28,
    localparam int TOTAL      = REG_COUNT * REG_W,
    localparam int IDX_W      = $clog2(REG_COUNT)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bus_ce_n,
    input  logic             bus_oe_n,
    input  logic             bus_we_n,
    input  logic             bus_sel,
    input  logic             bus_dq0_i,
    input  logic             xfer_rst_n,
    input  logic [TOTAL-1:0] tk_rd_data,
    output logic             mem_inhibit,
    output logic             dq0_out,
    output logic             dq0_oe,
    output logic             tk_wr_en,
    output logic [IDX_W-1:0] tk_wr_idx,
    output logic [REG_W-1:0] tk_wr_byte
);

    bus_ev_t ev;
    logic    live_ce_n, live_oe_n, live_we_n, live_sel, live_rst_n;
    logic    key_done;
    logic    unlocked;

    skp_bus_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst        (rst),
        .bus_ce_n   (bus_ce_n),
        .bus_oe_n   (bus_oe_n),
        .bus_we_n   (bus_we_n),
        .bus_sel    (bus_sel),
        .bus_dq0_i  (bus_dq0_i),
        .xfer_rst_n (xfer_rst_n),
        .live_ce_n  (live_ce_n),
        .live_oe_n  (live_oe_n),
        .live_we_n  (live_we_n),
        .live_sel   (live_sel),
        .live_rst_n (live_rst_n),
        .ev         (ev)
    );

    skp_key_match u_key (
        .clk      (clk),
        .rst      (rst),
        .locked_i (!unlocked),
        .ev       (ev),
        .done_o   (key_done)
    );

    skp_xfer #(.REG_COUNT(REG_COUNT), .REG_W(REG_W), .RSTEN_BIT(RSTEN_BIT)) u_xfer (
        .clk        (clk),
        .rst        (rst),
        .ev         (ev),
        .start_i    (key_done),
        .live_ce_n  (live_ce_n),
        .live_oe_n  (live_oe_n),
        .live_we_n  (live_we_n),
        .live_sel   (live_sel),
        .live_rst_n (live_rst_n),
        .tk_rd_data (tk_rd_data),
        .unlocked_o (unlocked),
        .dq_out     (dq0_out),
        .dq_oe      (dq0_oe),
        .wr_en      (tk_wr_en),
        .wr_idx     (tk_wr_idx),
        .wr_byte    (tk_wr_byte)
    );

    assign mem_inhibit = unlocked;

    // R2: the port only opens on a completed key
    assert_unlock_needs_key_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_inhibit) |-> $past(key_done));

endmodule

// File: tb/keyed_serial_port_tb.sv
module keyed_serial_port_tb;

    localparam int          CLK_PERIOD = 10;
    localparam logic [63:0] KEY = 64'h5CA3_3AC5_5CA3_3AC5;
    localparam logic [63:0] TK1 = 64'hF1E2_D3C4_B5A6_9788;  // bit 28 = 1
    localparam logic [63:0] TK2 = 64'h1122_3344_4566_7788;  // bit 28 = 0
    localparam logic [63:0] WP  = 64'h0123_4567_89AB_CDEF;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, sel = 1'b0, din = 1'b0;
    logic        rpin_n = 1'b1;
    logic [63:0] tk = TK1;
    logic        mem_inhibit, dq0_out, dq0_oe, tk_wr_en;
    logic [2:0]  tk_wr_idx;
    logic [7:0]  tk_wr_byte;

    always #(CLK_PERIOD/2) clk = ~clk;

    keyed_serial_port u_dut (
        .clk(clk), .rst(rst), .bus_ce_n(ce_n), .bus_oe_n(oe_n), .bus_we_n(we_n),
        .bus_sel(sel), .bus_dq0_i(din), .xfer_rst_n(rpin_n), .tk_rd_data(tk),
        .mem_inhibit(mem_inhibit), .dq0_out(dq0_out), .dq0_oe(dq0_oe),
        .tk_wr_en(tk_wr_en), .tk_wr_idx(tk_wr_idx), .tk_wr_byte(tk_wr_byte)
    );

    int checks = 0;
    int failures = 0;
    bit done = 0;
    bit cmp_on = 0;
    int wr_seen = 0;

    // behavioural model
    int          m_ptr = 0;
    bit          m_miss = 0;
    bit          m_unl = 0;
    int          m_cnt = 0;
    logic [63:0] m_shadow = '0;
    logic [7:0]  m_byte_acc = '0;
    bit          m_dirty = 0;
    bit          m_wr = 0;
    int          m_idx = 0;
    logic [7:0]  m_wbyte = '0;

    typedef struct packed {
        logic       inh;
        logic       oe;
        logic       dout;
        logic       wr;
        logic [2:0] idx;
        logic [7:0] wbyte;
    } exp_t;

    exp_t hist [3];
    initial for (int i = 0; i < 3; i++) hist[i] = '0;

    always @(posedge clk) begin
        exp_t cur;
        cur.inh   = m_unl;
        cur.oe    = m_unl && !ce_n && !oe_n && we_n && sel;
        cur.dout  = m_shadow[m_cnt % 64];
        cur.wr    = m_wr;
        cur.idx   = 3'(m_idx);
        cur.wbyte = m_wbyte;
        hist[2] = hist[1];
        hist[1] = hist[0];
        hist[0] = cur;
        m_wr = 0;
    end

    task automatic chk(input logic [63:0] got, input logic [63:0] exp, input string what);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", what, got, exp);
        end
    endtask

    // per-clock comparison against the delayed model
    always @(negedge clk) begin
        if (cmp_on) begin
            chk(64'(mem_inhibit), 64'(hist[2].inh), "R2 R8 mem_inhibit per clock");
            chk(64'(dq0_oe), 64'(hist[1].oe), "R6 dq0_oe per clock");
            if (hist[1].oe) chk(64'(dq0_out), 64'(hist[1].dout), "R6 dq0_out per clock");
            chk(64'(tk_wr_en), 64'(hist[2].wr), "R7 tk_wr_en per clock");
            if (hist[2].wr) begin
                chk(64'(tk_wr_idx), 64'(hist[2].idx), "R7 tk_wr_idx");
                chk(64'(tk_wr_byte), 64'(hist[2].wbyte), "R7 tk_wr_byte");
            end
            if (tk_wr_en) wr_seen++;
        end
    end

    task automatic model_apply(input bit wr, input bit rd, input bit s, input bit b);
        int g, p;
        if (!s || (!wr && !rd)) return;
        if (!m_unl) begin
            if (!wr) begin
                m_ptr = 0;
                m_miss = 0;
            end else if (!m_miss) begin
                if (b == KEY[m_ptr]) begin
                    m_ptr++;
                    if (m_ptr == 64) begin
                        m_unl = 1; m_ptr = 0; m_cnt = 0;
                        m_shadow = tk; m_byte_acc = tk[7:0]; m_dirty = 0;
                    end
                end else m_miss = 1;
            end
        end else begin
            g = m_cnt / 8;
            p = m_cnt % 8;
            if (wr) begin
                m_byte_acc[p] = b;
                m_dirty = 1;
            end
            if (p == 7) begin
                if (m_dirty) begin
                    m_wr = 1; m_idx = g; m_wbyte = m_byte_acc;
                end
                m_dirty = 0;
                if (g < 7) m_byte_acc = m_shadow[(g+1)*8 +: 8];
            end
            m_cnt++;
            if (m_cnt == 64) m_unl = 0;
        end
    endtask

    task automatic bus_cycle(input bit wr, input bit rd, input bit s, input bit b);
        @(negedge clk);
        ce_n = 0; we_n = !wr; oe_n = !rd; sel = s; din = b;
        repeat (3) @(negedge clk);
        if (rd && !wr && s && m_unl) begin
            chk(64'(dq0_oe), 64'd1, "R6 dq0_oe during read");
            chk(64'(dq0_out), 64'(m_shadow[m_cnt]), "R6 dq0_out bit");
        end
        ce_n = 1;
        model_apply(wr, rd, s, b);
        we_n = 1; oe_n = 1; sel = 0; din = 0;
        repeat (4) @(negedge clk);
    endtask

    task automatic send_key(input int from, input int upto);
        for (int i = from; i <= upto; i++) bus_cycle(1, 0, 1, KEY[i]);
    endtask

    task automatic pulse_abort();
        @(negedge clk);
        rpin_n = 0;
        if (m_unl && !tk[28]) begin
            m_unl = 0; m_cnt = 0; m_dirty = 0;
        end
        repeat (4) @(negedge clk);
        rpin_n = 1;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        int w0;
        repeat (5) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk(64'(mem_inhibit), 0, "R1 reset mem_inhibit");
        chk(64'(dq0_oe), 0, "R1 reset dq0_oe");
        chk(64'(tk_wr_en), 0, "R1 reset tk_wr_en");
        cmp_on = 1;

        // Phase 1: key with a neutral pulse mixed in, read transfer
        send_key(0, 19);
        bus_cycle(0, 0, 1, 0);            // R10 neutral pulse
        send_key(20, 62);
        chk(64'(mem_inhibit), 0, "R2 still locked before last key bit");
        send_key(63, 63);
        chk(64'(mem_inhibit), 1, "R2 R10 unlock after full key");
        for (int i = 0; i < 20; i++) bus_cycle(0, 1, 1, 0);
        pulse_abort();
        chk(64'(mem_inhibit), 1, "R9 reset input ignored with enable bit set");
        tk = TK1 ^ 64'hFFFF_FFFF_0000_0000;
        for (int i = 20; i < 64; i++) bus_cycle(0, 1, 1, 0);
        chk(64'(mem_inhibit), 0, "R8 locked after 64 cycles");
        tk = TK1;

        // Phase 2: mismatch freeze, then read restart and write transfer
        bus_cycle(1, 0, 1, !KEY[0]);
        send_key(0, 63);
        chk(64'(mem_inhibit), 0, "R3 key ignored after mismatch");
        bus_cycle(0, 1, 1, 0);
        send_key(0, 63);
        chk(64'(mem_inhibit), 1, "R4 unlock after read restart");
        w0 = wr_seen;
        for (int i = 0; i < 64; i++) bus_cycle(1, 0, 1, WP[i]);
        chk(64'(wr_seen - w0), 8, "R7 eight register writes");
        chk(64'(tk_wr_idx), 7, "R7 last register index");
        chk(64'(tk_wr_byte), 64'(WP[63:56]), "R7 last register value");
        chk(64'(mem_inhibit), 0, "R8 locked after write transfer");

        // Phase 3: read in the middle of the key aborts it
        send_key(0, 9);
        bus_cycle(0, 1, 1, 0);
        send_key(10, 63);
        chk(64'(mem_inhibit), 0, "R4 read mid-key aborts");

        // Phase 4: unselected cycles mixed in, partial writes, abort
        bus_cycle(0, 1, 1, 0);
        tk = TK2;
        for (int i = 0; i < 64; i++) begin
            bus_cycle(1, 0, 0, !KEY[i]);
            if (i % 8 == 3) bus_cycle(0, 1, 0, 0);
            bus_cycle(1, 0, 1, KEY[i]);
        end
        chk(64'(mem_inhibit), 1, "R5 unselected cycles ignored in key");
        w0 = wr_seen;
        bus_cycle(1, 0, 1, 1);
        bus_cycle(1, 0, 1, 0);
        bus_cycle(0, 1, 0, 0);
        bus_cycle(1, 0, 1, 1);
        bus_cycle(1, 0, 0, 0);
        bus_cycle(1, 0, 1, 1);
        for (int i = 4; i < 8; i++) bus_cycle(0, 1, 1, 0);
        chk(64'(wr_seen - w0), 1, "R7 one write for mixed register");
        chk(64'(tk_wr_byte), 64'({TK2[7:4], 4'b1101}), "R5 R7 mixed register value");
        for (int i = 0; i < 8; i++) bus_cycle(0, 1, 1, 0);
        chk(64'(wr_seen - w0), 1, "R7 no write for read-only register");
        for (int i = 0; i < 3; i++) bus_cycle(1, 0, 1, 1);
        pulse_abort();
        repeat (4) @(negedge clk);
        chk(64'(mem_inhibit), 0, "R9 abort locks port");
        chk(64'(wr_seen - w0), 1, "R9 no write for partial register");

        repeat (6) @(negedge clk);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule